// File: doc/BRIEF.md
# Single-Step Run Control Unit

This block produces the ready (wait) line of a processor from three operator inputs: a run switch, a step push-button and an external wait request. With the run switch raised, the processor runs freely and ready drops only on a wait request. With the run latch cleared, the processor halts at each stop point. Each press of the step button then releases exactly one stop point.

The run and step inputs come from mechanical switches. Each one passes through a two-flop synchronizer. A step press starts a long debounce window, and further edges inside that window are ignored. An accepted press does two things: it clears the run latch, and it arms a pending-step flag. The flag stays set until the processor moves through a stop point, and then it clears.

A static mode input selects which machine cycles count as stop points:
- every cycle that asserts the memory-request strobe, or
- only those cycles that also flag an opcode fetch. In this mode the remaining bytes of a multi-byte instruction run through without stopping.

Top module: `cpu_step_ctrl`

## Requirements
- R1: While `rst_n` is low, `ready` is 0. Reset clears the run latch and any pending step, so after reset `ready` stays 0 at a stop point until run or step is applied.
- R2: A change on `run_in` or `step_btn` takes effect in `ready` after the third rising clock edge (two synchronizer flops plus an edge register).
- R3: One accepted step press lets exactly one stop point through. The pending step clears on the clock edge at which a stop point completes with `ready` high.
- R4: A rising edge of the synchronized step input is ignored if it comes within `DEB_CYC` cycles after an accepted press. Bounce and a held button therefore yield one step.
- R5: An accepted step press clears the run latch, even while `run_in` is high. The latch is set only by a rising edge of the synchronized run input and is cleared when that input is low, so resuming free run needs `run_in` to be lowered and raised again.
- R6: `ready` is 0 in any cycle where `wait_req` is 1, in the same cycle.
- R7: With the run latch set and `wait_req` low, `ready` is 1 every cycle in either step mode.
- R8: With `step_mode` = 0 (per-cycle), every cycle with `cyc_req` = 1 is a stop point.
- R9: With `step_mode` = 1 (per-instruction), only cycles with `cyc_req` = 1 and `opfetch` = 1 are stop points. Any other cycle has `ready` = 1 unless `wait_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_in | input | 1 | Run switch, asynchronous |
| step_btn | input | 1 | Step push-button, asynchronous, may bounce |
| wait_req | input | 1 | External wait request, synchronous |
| step_mode | input | 1 | 0 = stop every machine cycle, 1 = stop only on opcode fetch |
| cyc_req | input | 1 | Memory-request strobe, high for every clock of a machine cycle |
| opfetch | input | 1 | Opcode-fetch indicator for the current cycle |
| ready | output | 1 | 1 lets the current cycle complete, 0 holds it |

## Verification
Changes on `run_in` and `step_btn` reach `ready` after the third rising edge. A wait request acts combinationally in the same cycle. A pending step clears on the edge at which its cycle completes.

A reference model in the bench holds its state in queues and integers. It updates that state at each rising edge and compares `ready` at every falling edge, after the edge update and before new inputs are driven.

The bench also models the processor as a counter of completed cycles. Step, bounce and mode checks read that counter only after idle windows longer than both the three-edge latency and the debounce window, so each expected count is a settled total.

// File: rtl/step_pkg.sv
package step_pkg;

  typedef enum logic {
    STEP_EVERY_CYCLE = 1'b0,
    STEP_OPCODE_ONLY = 1'b1
  } step_mode_e;

  // A cycle holds for a stop only if it is a memory cycle that the mode selects.
  function automatic logic is_stop_point(input step_mode_e mode,
                                         input logic cyc_req,
                                         input logic opfetch);
    return cyc_req && ((mode == STEP_EVERY_CYCLE) || opfetch);
  endfunction

  // Debounce count: reload on an accepted press, else run down to zero.
  function automatic int unsigned lock_next(input int unsigned cur,
                                            input logic fire,
                                            input int unsigned load);
    if (fire) return load;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

endpackage

// File: rtl/step_sync.sv
module step_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[b]   <= 1'b0;
        sync_out[b] <= 1'b0;
      end else begin
        meta_q[b]   <= async_in[b];
        sync_out[b] <= meta_q[b];
      end
    end
  end
endmodule

// File: rtl/step_debounce.sv
module step_debounce #(
  parameter int unsigned DEB_CYC = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_s,
  output logic step_fire
);
  import step_pkg::*;

  localparam int unsigned CW = $clog2(DEB_CYC + 1);

  logic          step_q;
  logic [CW-1:0] lock_cnt;
  logic          step_edge;
  logic          lock_idle;

  assign step_edge = step_s && !step_q;
  assign lock_idle = (lock_cnt == '0);
  assign step_fire = step_edge && lock_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= 1'b0;
      lock_cnt <= '0;
    end else begin
      step_q   <= step_s;
      lock_cnt <= CW'(lock_next(int'(lock_cnt), step_fire, DEB_CYC));
    end
  end

  // R4
  no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> !step_fire);

  // R4
  lock_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> !lock_idle);
endmodule

// File: rtl/run_step_hold.sv
module run_step_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic run_s,
  input  logic step_fire,
  input  logic stop_pt,
  input  logic ready,
  output logic run_lat,
  output logic pend
);
  logic run_q;
  logic run_edge;
  logic consume;

  assign run_edge = run_s && !run_q;
  assign consume  = pend && stop_pt && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      run_lat <= 1'b0;
      pend    <= 1'b0;
    end else begin
      run_q <= run_s;
      if (step_fire)     run_lat <= 1'b0;
      else if (run_edge) run_lat <= 1'b1;
      else if (!run_s)   run_lat <= 1'b0;
      if (step_fire)     pend <= 1'b1;
      else if (consume)  pend <= 1'b0;
    end
  end

  // R5
  step_stops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> !run_lat);

  // R3
  pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(step_fire));

  // R3
  pend_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !step_fire) |=> !pend);
endmodule

// File: rtl/cpu_step_ctrl.sv
module cpu_step_ctrl #(
  parameter int unsigned DEB_CYC = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_in,
  input  logic step_btn,
  input  logic wait_req,
  input  logic step_mode,
  input  logic cyc_req,
  input  logic opfetch,
  output logic ready
);
  import step_pkg::*;

  logic [1:0] sw_sync;
  logic       run_s;
  logic       step_s;
  logic       step_fire;
  logic       stop_pt;
  logic       run_lat;
  logic       pend;

  step_sync #(.W(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({step_btn, run_in}),
    .sync_out (sw_sync)
  );
  assign run_s  = sw_sync[0];
  assign step_s = sw_sync[1];

  step_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_s    (step_s),
    .step_fire (step_fire)
  );

  assign stop_pt = is_stop_point(step_mode_e'(step_mode), cyc_req, opfetch);

  run_step_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_s     (run_s),
    .step_fire (step_fire),
    .stop_pt   (stop_pt),
    .ready     (ready),
    .run_lat   (run_lat),
    .pend      (pend)
  );

  assign ready = rst_n && !wait_req && (run_lat || pend || !stop_pt);

  // R6
  wait_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |-> !ready);

  // R9
  instr_runthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_mode && cyc_req && !opfetch && !wait_req) |-> ready);

  // R7
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_lat && !wait_req) |-> ready);

  // R8
  halt_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_mode && cyc_req && !run_lat && !pend) |-> !ready);

  // R1
  always_comb begin
    if (!rst_n) reset_quiet_chk: assert (!ready);
  end
endmodule

// File: tb/cpu_step_ctrl_tb_top.sv
`timescale 1ns/1ps
module cpu_step_ctrl_tb_top;
  localparam int DEB = 8;
  localparam int INSTR_LEN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_in = 1'b0, step_btn = 1'b0, wait_req = 1'b0;
  logic step_mode = 1'b0, cyc_req = 1'b1, opfetch = 1'b1;
  logic ready;

  int n_cmp = 0, n_bad = 0;
  int done_cyc = 0;   // completed CPU cycles
  int phase = 0;      // byte index inside the current instruction
  int cyc_total = 0;
  bit finished = 0;

  // reference model state
  int rh[$], sh[$];
  int m_lock = 0;
  bit m_run = 0, m_pend = 0;

  always #2.5 clk = ~clk;

  cpu_step_ctrl #(.DEB_CYC(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_in(run_in), .step_btn(step_btn),
    .wait_req(wait_req), .step_mode(step_mode), .cyc_req(cyc_req),
    .opfetch(opfetch), .ready(ready)
  );

  function automatic bit m_stop();
    return cyc_req && (step_mode == 1'b0 || opfetch);
  endfunction

  function automatic bit m_ready();
    return rst_n && !wait_req && (m_run || m_pend || !m_stop());
  endfunction

  initial begin
    for (int i = 0; i < 3; i++) begin rh.push_back(0); sh.push_back(0); end
  end

  always @(posedge clk) begin
    cyc_total++;
    if (!rst_n) begin
      rh = '{0, 0, 0}; sh = '{0, 0, 0};
      m_lock = 0; m_run = 0; m_pend = 0;
    end else begin
      bit rdy, fire, consume;
      rdy = m_ready();
      if (cyc_req && ready) begin
        done_cyc++;
        phase = (phase + 1) % INSTR_LEN;
      end
      fire = sh[1] && !sh[2] && (m_lock == 0);
      if (fire) m_run = 0;
      else if (rh[1] && !rh[2]) m_run = 1;
      else if (!rh[1]) m_run = 0;
      consume = m_pend && m_stop() && rdy;
      if (fire) m_pend = 1;
      else if (consume) m_pend = 0;
      if (fire) m_lock = DEB;
      else if (m_lock > 0) m_lock--;
      rh.push_front(int'(run_in)); void'(rh.pop_back());
      sh.push_front(int'(step_btn)); void'(sh.pop_back());
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One falling edge: compare against the model, then refresh the CPU fetch flag.
  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      chk("model ready", int'(ready), int'(m_ready()));
      opfetch = (phase == 0);
    end
  endtask

  task automatic press(input int hold);
    step_btn = 1'b1; tick(hold); step_btn = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    wait (cyc_total > 50000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected 0 cycles", cyc_total);
    finish_run();
  end

  initial begin
    int c0;
    run_in = 1'b1;
    tick(4);
    chk("R1 ready low in reset", int'(ready), 0);
    run_in = 1'b0;
    tick(1);
    rst_n = 1'b1;
    tick(6);
    chk("R1 stopped after reset", int'(ready), 0);
    c0 = done_cyc; tick(10);
    chk("R1 no cycles after reset", done_cyc - c0, 0);

    // R8 / R3: one step per press in per-cycle mode
    c0 = done_cyc; press(4); tick(20);
    chk("R3 one step per press", done_cyc - c0, 1);
    chk("R8 halted again", int'(ready), 0);

    // R4: bouncing press
    c0 = done_cyc;
    step_btn = 1; tick(1); step_btn = 0; tick(1); step_btn = 1; tick(1);
    step_btn = 0; tick(1); step_btn = 1; tick(2); step_btn = 0;
    tick(20);
    chk("R4 bounce gives one step", done_cyc - c0, 1);
    c0 = done_cyc; press(30); tick(20);
    chk("R4 held button one step", done_cyc - c0, 1);

    // R9: per-instruction mode
    step_mode = 1'b1; tick(10);
    chk("R9 halted on opcode fetch", int'(opfetch) * 2 + int'(ready), 2);
    c0 = done_cyc; press(4); tick(20);
    chk("R9 whole instruction per press", done_cyc - c0, INSTR_LEN);
    c0 = done_cyc; press(4); tick(20);
    chk("R9 second instruction", done_cyc - c0, INSTR_LEN);
    cyc_req = 1'b0; tick(2);
    chk("R9 idle bus not held", int'(ready), 1);
    cyc_req = 1'b1; step_mode = 1'b0; tick(5);

    // R2: run latency and R7 free run
    run_in = 1'b1; tick(2);
    chk("R2 run not yet seen", int'(ready), 0);
    tick(1);
    chk("R2 run on third edge", int'(ready), 1);
    c0 = done_cyc; tick(20);
    chk("R7 free run every cycle", done_cyc - c0, 20);

    // R6: wait request
    wait_req = 1'b1; c0 = done_cyc; tick(1);
    chk("R6 wait blocks ready", int'(ready), 0);
    tick(4);
    chk("R6 no cycles under wait", done_cyc - c0, 0);
    wait_req = 1'b0; tick(1);
    chk("R6 resumes after wait", int'(ready), 1);

    // R5: step while running stops the processor, run must be re-raised
    press(4); tick(20);
    c0 = done_cyc; tick(20);
    chk("R5 step halts free run", done_cyc - c0, 0);
    chk("R5 latch stays clear with run high", int'(ready), 0);
    run_in = 1'b0; tick(5); run_in = 1'b1; tick(5);
    c0 = done_cyc; tick(10);
    chk("R5 re-raised run resumes", done_cyc - c0, 10);
    step_mode = 1'b1; c0 = done_cyc; tick(10);
    chk("R7 free run in instruction mode", done_cyc - c0, 10);
    run_in = 1'b0; tick(10);
    chk("R5 run low clears latch", int'(ready), 0);

    finish_run();
  end
endmodule